// File: doc/BRIEF.md
# Flash Bad Block Status Table

This block holds a two-bit status field for every erase block of a NAND flash array. The fields are packed four to a table byte, and the table is cleared synchronously during reset. A client presents a byte offset with a query strobe and receives a one-cycle response that says whether the block is bad. The same offset with a mark strobe records the block as bad and asks the flash command engine to write the bad-block marker into the spare area.

When the table is not trusted (`use_table` low), a query starts a scan instead of a table lookup. The block raises a marker-read request that carries the page, chip and spare column. It holds `busy` until the command engine returns the marker byte or word. It then judges the marker and stores a factory-bad code when the marker is bad. The spare column and the byte that is compared both depend on the bus width and on the marker position.

Top module: `bbt_status_table`

## Requirements
- R1: After reset every field reads good (00), and `rsp_valid`, `busy`, `rd_req` and `wr_req` are all low.
- R2: A query with `use_table` high while idle gives `rsp_valid` high on the next cycle. `rsp_bad` is 1 when the block's field is non-zero and 0 when the field is 00.
- R3: The block index is `ofs >> ERASE_SHIFT`. It selects table byte `index >> 2` and bit pair `(index & 3) * 2`. A mark ORs 01 into that field. Later queries report that block bad and leave every other block's result unchanged.
- R4: When a mark and a query arrive in the same cycle, the mark is applied first, so the query reports the block bad.
- R5: A mark gives a one-cycle `wr_req` on the next cycle. With it come `wr_data` = 0x0000, `wr_col` = MARK_POS with bit 0 cleared, `wr_page` = `(ofs >> PAGE_SHIFT)` masked to PAGE_W bits, and `wr_chip` = `ofs >> CHIP_SHIFT`.
- R6: A query with `use_table` low while idle raises `busy` and `rd_req` on the next cycle. The request carries `rd_page` and `rd_chip`, derived as in R5. `rd_col` is MARK_POS on an 8-bit bus (`bus16` = 0) and MARK_POS with bit 0 cleared on a 16-bit bus (`bus16` = 1).
- R7: On an 8-bit bus the scanned block is bad exactly when `rd_data[7:0]` is not 0xFF. The cycle after `rd_valid`, `rsp_valid` is high with that result and `busy` is low.
- R8: On a 16-bit bus only one byte of the returned word is compared with 0xFF. For an odd MARK_POS (the default, 5) that byte is `rd_data[15:8]`. For an even MARK_POS it is `rd_data[7:0]`.
- R9: A query while `busy` is high is ignored, and so is an `rd_valid` while idle. Neither produces `rsp_valid`.
- R10: A scan that finds a bad marker ORs 10 into the block's field, so later table queries report the block bad. A good marker leaves the field unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous; clears the table |
| qry_stb | input | 1 | Query strobe |
| mark_stb | input | 1 | Mark-bad strobe |
| ofs | input | OFS_W | Byte offset into the array |
| use_table | input | 1 | 1: answer from table, 0: scan the spare marker |
| bus16 | input | 1 | 1: 16-bit flash bus, 0: 8-bit |
| rd_valid | input | 1 | Command engine returns marker data |
| rd_data | input | 16 | Marker byte (low) or word |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_bad | output | 1 | Response: block is bad |
| busy | output | 1 | Waiting for marker data |
| rd_req | output | 1 | Marker-read request to the command engine |
| rd_page | output | PAGE_W | Page address for marker read |
| rd_chip | output | CHIP_W | Chip index for marker read |
| rd_col | output | 8 | Spare column for marker read |
| wr_req | output | 1 | One-cycle marker-write request |
| wr_page | output | PAGE_W | Page address for marker write |
| wr_chip | output | CHIP_W | Chip index for marker write |
| wr_col | output | 8 | Spare column for marker write (even) |
| wr_data | output | 16 | Two marker bytes to write (zero) |

## Verification
The embedded assertions check the handshake timing on every cycle. A table query must answer the next cycle, a mark must raise the write request, a scan start must raise busy, and returned data must drop busy with a response. No response may appear while a scan waits without data, and a same-cycle mark and query must report bad. The values need the bench: the packing of four fields per byte, the independence of neighbouring blocks, the byte selected from a 16-bit marker word and the recorded factory-bad code. It sweeps every block of a small array under several mark patterns and marker values and computes the expected results arithmetically.

// File: rtl/bbt_pkg.sv
package bbt_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } bbt_state_e;

    localparam logic [1:0] FLD_GOOD    = 2'b00;
    localparam logic [1:0] FLD_MARKED  = 2'b01;
    localparam logic [1:0] FLD_FACTORY = 2'b10;
endpackage

// File: rtl/bbt_addr.sv
module bbt_addr #(
    parameter int OFS_W       = 20,
    parameter int ERASE_SHIFT = 14,
    parameter int PAGE_SHIFT  = 9,
    parameter int CHIP_SHIFT  = 19,
    parameter int BLK_W       = OFS_W - ERASE_SHIFT,
    parameter int PAGE_W      = CHIP_SHIFT - PAGE_SHIFT,
    parameter int CHIP_W      = OFS_W - CHIP_SHIFT
) (
    input  logic [OFS_W-1:0]  ofs,
    output logic [BLK_W-1:0]  blk,
    output logic [PAGE_W-1:0] page,
    output logic [CHIP_W-1:0] chip
);
    // Truncation to PAGE_W bits acts as the page mask.
    always_comb begin
        blk  = BLK_W'(ofs >> ERASE_SHIFT);
        page = PAGE_W'(ofs >> PAGE_SHIFT);
        chip = CHIP_W'(ofs >> CHIP_SHIFT);
    end
endmodule

// File: rtl/bbt_marker_eval.sv
module bbt_marker_eval #(
    parameter int MARK_POS = 5
) (
    input  logic        col_wide,
    input  logic        chk_wide,
    input  logic [15:0] word,
    output logic [7:0]  col,
    output logic [7:0]  even_col,
    output logic        bad
);
    localparam logic [7:0] POS      = 8'(MARK_POS);
    localparam logic [7:0] POS_EVEN = {POS[7:1], 1'b0};

    logic [7:0] wide_byte;

    generate
        if (MARK_POS % 2 == 1) begin : g_odd
            assign wide_byte = word[15:8];
        end else begin : g_even
            assign wide_byte = word[7:0];
        end
    endgenerate

    always_comb begin
        col      = col_wide ? POS_EVEN : POS;
        even_col = POS_EVEN;
        bad      = chk_wide ? (wide_byte != 8'hFF) : (word[7:0] != 8'hFF);
    end
endmodule

// File: rtl/bbt_status_table.sv
module bbt_status_table
    import bbt_pkg::*;
#(
    parameter int OFS_W       = 20,
    parameter int ERASE_SHIFT = 14,
    parameter int PAGE_SHIFT  = 9,
    parameter int CHIP_SHIFT  = 19,
    parameter int MARK_POS    = 5,
    localparam int BLK_W      = OFS_W - ERASE_SHIFT,
    localparam int PAGE_W     = CHIP_SHIFT - PAGE_SHIFT,
    localparam int CHIP_W     = OFS_W - CHIP_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              qry_stb,
    input  logic              mark_stb,
    input  logic [OFS_W-1:0]  ofs,
    input  logic              use_table,
    input  logic              bus16,
    input  logic              rd_valid,
    input  logic [15:0]       rd_data,
    output logic              rsp_valid,
    output logic              rsp_bad,
    output logic              busy,
    output logic              rd_req,
    output logic [PAGE_W-1:0] rd_page,
    output logic [CHIP_W-1:0] rd_chip,
    output logic [7:0]        rd_col,
    output logic              wr_req,
    output logic [PAGE_W-1:0] wr_page,
    output logic [CHIP_W-1:0] wr_chip,
    output logic [7:0]        wr_col,
    output logic [15:0]       wr_data
);
    localparam int NBLK      = 1 << BLK_W;
    localparam int TBL_BYTES = NBLK / 4;
    localparam int IDX_W     = BLK_W - 2;

    typedef struct packed {
        bbt_state_e                    state;
        logic [TBL_BYTES-1:0][7:0]     tbl;
        logic [BLK_W-1:0]              blk;
        logic                          wide;
        logic [PAGE_W-1:0]             rd_page;
        logic [CHIP_W-1:0]             rd_chip;
        logic [7:0]                    rd_col;
        logic                          rsp_valid;
        logic                          rsp_bad;
        logic                          wr_req;
        logic [PAGE_W-1:0]             wr_page;
        logic [CHIP_W-1:0]             wr_chip;
    } bbt_regs_t;

    bbt_regs_t reg_d, reg_q;

    logic [BLK_W-1:0]  cur_blk;
    logic [PAGE_W-1:0] cur_page;
    logic [CHIP_W-1:0] cur_chip;
    logic [7:0]        scan_col;
    logic [7:0]        mark_col;
    logic              marker_bad;

    bbt_addr #(
        .OFS_W      (OFS_W),
        .ERASE_SHIFT(ERASE_SHIFT),
        .PAGE_SHIFT (PAGE_SHIFT),
        .CHIP_SHIFT (CHIP_SHIFT),
        .BLK_W      (BLK_W),
        .PAGE_W     (PAGE_W),
        .CHIP_W     (CHIP_W)
    ) u_addr (
        .ofs (ofs),
        .blk (cur_blk),
        .page(cur_page),
        .chip(cur_chip)
    );

    bbt_marker_eval #(
        .MARK_POS(MARK_POS)
    ) u_eval (
        .col_wide(bus16),
        .chk_wide(reg_q.wide),
        .word    (rd_data),
        .col     (scan_col),
        .even_col(mark_col),
        .bad     (marker_bad)
    );

    // Next-state logic: mark first, then scan completion, then query.
    always_comb begin
        logic [IDX_W-1:0] m_idx;
        logic [2:0]       m_bit;
        logic [IDX_W-1:0] s_idx;
        logic [2:0]       s_bit;

        reg_d           = reg_q;
        reg_d.rsp_valid = 1'b0;
        reg_d.wr_req    = 1'b0;

        m_idx = cur_blk[BLK_W-1:2];
        m_bit = {cur_blk[1:0], 1'b0};
        s_idx = reg_q.blk[BLK_W-1:2];
        s_bit = {reg_q.blk[1:0], 1'b0};

        if (mark_stb) begin
            reg_d.tbl[m_idx][m_bit +: 2] = reg_d.tbl[m_idx][m_bit +: 2] | FLD_MARKED;
            reg_d.wr_req  = 1'b1;
            reg_d.wr_page = cur_page;
            reg_d.wr_chip = cur_chip;
        end

        if (reg_q.state == ST_SCAN) begin
            if (rd_valid) begin
                reg_d.state     = ST_IDLE;
                reg_d.rsp_valid = 1'b1;
                reg_d.rsp_bad   = marker_bad;
                if (marker_bad) begin
                    reg_d.tbl[s_idx][s_bit +: 2] = reg_d.tbl[s_idx][s_bit +: 2] | FLD_FACTORY;
                end
            end
        end else if (qry_stb) begin
            if (use_table) begin
                reg_d.rsp_valid = 1'b1;
                reg_d.rsp_bad   = (reg_d.tbl[m_idx][m_bit +: 2] != FLD_GOOD);
            end else begin
                reg_d.state   = ST_SCAN;
                reg_d.blk     = cur_blk;
                reg_d.wide    = bus16;
                reg_d.rd_page = cur_page;
                reg_d.rd_chip = cur_chip;
                reg_d.rd_col  = scan_col;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q <= '{state: ST_IDLE, default: '0};
        end else begin
            reg_q <= reg_d;
        end
    end

    assign rsp_valid = reg_q.rsp_valid;
    assign rsp_bad   = reg_q.rsp_bad;
    assign busy      = (reg_q.state == ST_SCAN);
    assign rd_req    = (reg_q.state == ST_SCAN);
    assign rd_page   = reg_q.rd_page;
    assign rd_chip   = reg_q.rd_chip;
    assign rd_col    = reg_q.rd_col;
    assign wr_req    = reg_q.wr_req;
    assign wr_page   = reg_q.wr_page;
    assign wr_chip   = reg_q.wr_chip;
    assign wr_col    = mark_col;
    assign wr_data   = 16'h0000;

    // R2
    table_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (qry_stb && use_table && !busy) |=> rsp_valid);

    // R4
    mark_before_query_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (qry_stb && mark_stb && use_table && !busy) |=> (rsp_valid && rsp_bad));

    // R5
    mark_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mark_stb |=> wr_req);

    // R6
    scan_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (qry_stb && !use_table && !busy) |=> (busy && !rsp_valid));

    // R7
    scan_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_valid) |=> (!busy && rsp_valid));

    // R9
    no_early_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rd_valid) |=> !rsp_valid);
endmodule

// File: tb/bbt_status_table_bench.sv
module bbt_status_table_bench;
    localparam int OFS_W = 20;
    localparam int ES    = 14;
    localparam int PS    = 9;
    localparam int CS    = 19;
    localparam int NBLK  = 1 << (OFS_W - ES);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        qry_stb = 1'b0, mark_stb = 1'b0, use_table = 1'b1, bus16 = 1'b0;
    logic        rd_valid = 1'b0;
    logic [15:0] rd_data = '0;
    logic [OFS_W-1:0] ofs = '0;
    logic        rsp_valid, rsp_bad, busy, rd_req, wr_req;
    logic [9:0]  rd_page, wr_page;
    logic [0:0]  rd_chip, wr_chip;
    logic [7:0]  rd_col, wr_col;
    logic [15:0] wr_data;

    int n_cmp = 0;
    int n_bad = 0;
    logic [1:0] model [NBLK];

    always #10 clk = ~clk;

    bbt_status_table u_bbt_status_table (
        .clk(clk), .rst_n(rst_n), .qry_stb(qry_stb), .mark_stb(mark_stb), .ofs(ofs),
        .use_table(use_table), .bus16(bus16), .rd_valid(rd_valid), .rd_data(rd_data),
        .rsp_valid(rsp_valid), .rsp_bad(rsp_bad), .busy(busy), .rd_req(rd_req),
        .rd_page(rd_page), .rd_chip(rd_chip), .rd_col(rd_col), .wr_req(wr_req),
        .wr_page(wr_page), .wr_chip(wr_chip), .wr_col(wr_col), .wr_data(wr_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [OFS_W-1:0] mk_ofs(input int b, input int salt);
        return OFS_W'((b << ES) | (((salt * 7) % 32) << PS) | ((salt * 13) % 512));
    endfunction

    task automatic tbl_query(input int b, input string tag);
        ofs = mk_ofs(b, b + 3); use_table = 1'b1; qry_stb = 1'b1;
        @(negedge clk); qry_stb = 1'b0;
        chk({tag, " rsp_valid"}, 32'(rsp_valid), 1);
        chk({tag, " rsp_bad"}, 32'(rsp_bad), 32'(model[b] != 2'b00));
    endtask

    task automatic mark_blk(input int b);
        logic [OFS_W-1:0] o;
        o = mk_ofs(b, b);
        ofs = o; mark_stb = 1'b1;
        @(negedge clk); mark_stb = 1'b0;
        model[b] = model[b] | 2'b01;
        chk("R5 wr_req", 32'(wr_req), 1);
        chk("R5 wr_page", 32'(wr_page), 32'((o >> PS) & 10'h3FF));
        chk("R5 wr_chip", 32'(wr_chip), 32'(o >> CS));
        chk("R5 wr_col", 32'(wr_col), 4);
        chk("R5 wr_data", 32'(wr_data), 0);
    endtask

    task automatic scan(input int b, input logic wide, input logic [15:0] d, input logic exp_bad,
                        input string tag);
        logic [OFS_W-1:0] o;
        o = mk_ofs(b, b + 11);
        ofs = o; use_table = 1'b0; bus16 = wide; qry_stb = 1'b1;
        @(negedge clk); qry_stb = 1'b0; use_table = 1'b1;
        chk("R6 busy", 32'(busy), 1);
        chk("R6 rd_req", 32'(rd_req), 1);
        chk("R6 rd_col", 32'(rd_col), wide ? 4 : 5);
        chk("R6 rd_page", 32'(rd_page), 32'((o >> PS) & 10'h3FF));
        chk("R6 rd_chip", 32'(rd_chip), 32'(o >> CS));
        chk("R6 no rsp yet", 32'(rsp_valid), 0);
        rd_data = d; rd_valid = 1'b1;
        @(negedge clk); rd_valid = 1'b0;
        chk({tag, " rsp_valid"}, 32'(rsp_valid), 1);
        chk({tag, " rsp_bad"}, 32'(rsp_bad), 32'(exp_bad));
        chk({tag, " busy released"}, 32'(busy), 0);
        if (exp_bad) model[b] = model[b] | 2'b10;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NBLK; i++) model[i] = 2'b00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rsp_valid", 32'(rsp_valid), 0);
        chk("R1 busy", 32'(busy), 0);
        chk("R1 rd_req", 32'(rd_req), 0);
        chk("R1 wr_req", 32'(wr_req), 0);
        for (int b = 0; b < NBLK; b++) tbl_query(b, "R1 R2 clear sweep");

        // R3 mark every third block, then sweep all
        for (int b = 0; b < NBLK; b += 3) mark_blk(b);
        for (int b = 0; b < NBLK; b++) tbl_query(b, "R3 mark sweep");
        // R3 fill the rest of one byte group
        mark_blk(61); mark_blk(62);
        for (int b = 56; b < NBLK; b++) tbl_query(b, "R3 neighbour sweep");

        // R4 mark and query in one cycle
        ofs = mk_ofs(1, 1); mark_stb = 1'b1; qry_stb = 1'b1; use_table = 1'b1;
        @(negedge clk); mark_stb = 1'b0; qry_stb = 1'b0; model[1] = model[1] | 2'b01;
        chk("R4 rsp_valid", 32'(rsp_valid), 1);
        chk("R4 rsp_bad", 32'(rsp_bad), 1);

        // R7 8-bit scans
        scan(2, 1'b0, 16'h12FF, 1'b0, "R7 8bit FF");
        scan(4, 1'b0, 16'hFF00, 1'b1, "R7 8bit 00");
        scan(8, 1'b0, 16'hFF7F, 1'b1, "R7 8bit 7F");
        // R8 16-bit scans, odd marker position -> high byte
        scan(5, 1'b1, 16'h00FF, 1'b1, "R8 16bit hi00");
        scan(7, 1'b1, 16'hFF00, 1'b0, "R8 16bit hiFF");
        scan(10, 1'b1, 16'hFEFF, 1'b1, "R8 16bit hiFE");

        // R10 scan results stored in the table
        for (int b = 0; b < 16; b++) tbl_query(b, "R10 recorded");

        // R9 query during busy ignored
        ofs = mk_ofs(11, 0); use_table = 1'b0; qry_stb = 1'b1;
        @(negedge clk); use_table = 1'b1;
        @(negedge clk); qry_stb = 1'b0;
        chk("R9 query while busy", 32'(rsp_valid), 0);
        chk("R9 still busy", 32'(busy), 1);
        rd_data = 16'hFFFF; rd_valid = 1'b1;
        @(negedge clk); rd_valid = 1'b0;
        chk("R9 scan completes", 32'(rsp_valid), 1);
        chk("R9 scan good", 32'(rsp_bad), 0);
        // R9 rd_valid while idle ignored
        rd_data = 16'h0000; rd_valid = 1'b1;
        @(negedge clk); rd_valid = 1'b0;
        chk("R9 stray rd_valid", 32'(rsp_valid), 0);
        chk("R9 stray busy", 32'(busy), 0);
        tbl_query(11, "R9 field untouched");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule